// File: doc/BRIEF.md
# Double-Buffered Compare Value Loader

This block sits between the software-visible compare register of one timer channel and the comparator that the channel actually uses. Software writes a new compare value into a staging register at any time; the value reaches the working compare latch only at a transfer moment picked by a two-bit load-select field. Tying the transfer to the counter keeps a running output waveform free of glitches or shortened pulses when the value changes mid-period.

The transfer moment can be the write itself, the counter passing zero, zero or the period value (the period is only a transfer point when counting up/down), or the counter meeting the channel's own working compare value. The block also reports, every cycle, whether the counter equals the working latch. The channel can be placed in capture mode, in which case the working latch is frozen. The counter and any grouping of channels are outside the block. The block takes the counter value, the period value and the counting mode as inputs.

Top module: `cmp_latch_loader`

## Requirements
- R1: An active-low asynchronous reset clears both the staging register and the working latch to zero.
- R2: With load select 0 (`ld_sel`=2'b00) in compare mode, a write puts `wr_data` into the working latch on the same clock edge that stores it in the staging register.
- R3: With load select 1 (`ld_sel`=2'b01) in compare mode, the working latch takes the staging value on each clock edge where `cnt` is 0, and holds otherwise.
- R4: With load select 2 (`ld_sel`=2'b10) and up/down counting (`cnt_mode`=2'b11), the working latch takes the staging value on each edge where `cnt` equals 0 or equals `period`.
- R5: With load select 2 and any other counting mode (2'b00 halted, 2'b01 up, 2'b10 continuous), the working latch takes the staging value only where `cnt` is 0; `cnt`==`period` causes no transfer.
- R6: With load select 3 (`ld_sel`=2'b11) in compare mode, the working latch takes the staging value on each edge where `cnt` equals the current working latch value.
- R7: A staged value waits until its transfer moment; a later write before that moment replaces it, and only the latest value is transferred.
- R8: While `cap_mode` is 1 the working latch keeps its value regardless of writes or counter events; writes still update the staging register.
- R9: `match` is high exactly when `cnt` equals the working latch value in force before the clock edge, so it is unaffected by a transfer made at that same edge.
- R10: For load selects 1 to 3, a write made in the same cycle as a transfer moment is not part of that transfer: the previous staging value is transferred and the new value waits for the next moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the staging register |
| wr_data | input | W | Value written to the staging register |
| cnt | input | W | Current counter value |
| period | input | W | Period value of the counter |
| cnt_mode | input | 2 | 00 halted, 01 up, 10 continuous, 11 up/down |
| ld_sel | input | 2 | Transfer moment select (see R2 to R6) |
| cap_mode | input | 1 | 1 selects capture mode and freezes the latch |
| latch_q | output | W | Working compare latch value |
| match | output | 1 | Counter equals working latch |

## Verification
A wrong staging value stays invisible until the next transfer moment, so the bench always forces a transfer after staging and reads `latch_q` one edge later; an early transfer shows the moment it happens, so each select is also probed at a non-event counter value. A fault in event decoding is caught by putting the counter on the event value of another select (zero, period, latch value) and checking that nothing moved. `match` is compared in the cycle before and after a self-triggered transfer, which exposes a comparator reading the post-load value.

// File: rtl/cmp_latch_loader.sv
module cmp_latch_loader #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] period,
  input  logic [1:0]   cnt_mode,
  input  logic [1:0]   ld_sel,
  input  logic         cap_mode,
  output logic [W-1:0] latch_q,
  output logic         match
);

  localparam logic [1:0] SEL_WRITE = 2'b00;
  localparam logic [1:0] SEL_ZERO  = 2'b01;
  localparam logic [1:0] SEL_ENDS  = 2'b10;
  localparam logic [1:0] SEL_SELF  = 2'b11;
  localparam logic [1:0] MODE_UPDN = 2'b11;

  logic [W-1:0] ccr_q;
  logic         at_zero, at_period, at_self, updn;
  logic         event_hit;

  assign at_zero   = (cnt == '0);
  assign at_period = (cnt == period);
  assign at_self   = (cnt == latch_q);
  assign updn      = (cnt_mode == MODE_UPDN);
  assign match     = at_self;

  always_comb begin
    unique case (ld_sel)
      SEL_WRITE: event_hit = 1'b0;
      SEL_ZERO:  event_hit = at_zero;
      SEL_ENDS:  event_hit = at_zero | (updn & at_period);
      SEL_SELF:  event_hit = at_self;
      default:   event_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ccr_q <= '0;
    else if (wr_en)
      ccr_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      latch_q <= '0;
    else if (!cap_mode) begin
      if (ld_sel == SEL_WRITE && wr_en)
        latch_q <= wr_data;
      else if (event_hit)
        latch_q <= ccr_q;
    end
  end

endmodule

module cmp_latch_loader_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic [1:0]   cnt_mode,
  input logic [1:0]   ld_sel,
  input logic         cap_mode,
  input logic [W-1:0] ccr_q,
  input logic [W-1:0] latch_q
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (latch_q == '0 && ccr_q == '0)); // R1

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && ld_sel == 2'b00 && wr_en) |=> latch_q == $past(wr_data)); // R2

  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && ld_sel == 2'b01 && cnt == '0) |=> latch_q == $past(ccr_q)); // R3

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == 2'b01 && cnt != '0) |=> $stable(latch_q)); // R3

  AST_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && ld_sel == 2'b10 && cnt_mode == 2'b11 && cnt == period) |=> latch_q == $past(ccr_q)); // R4

  AST_ENDS_NOPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == 2'b10 && cnt_mode != 2'b11 && cnt != '0) |=> $stable(latch_q)); // R5

  AST_SELF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && ld_sel == 2'b11 && cnt == latch_q) |=> latch_q == $past(ccr_q)); // R6

  AST_CAPTURE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |=> $stable(latch_q)); // R8

endmodule

bind cmp_latch_loader cmp_latch_loader_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cnt(cnt),
  .period(period), .cnt_mode(cnt_mode), .ld_sel(ld_sel), .cap_mode(cap_mode),
  .ccr_q(ccr_q), .latch_q(latch_q)
);

// File: tb/cmp_latch_loader_bench.sv
module cmp_latch_loader_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt = 16'd5;
  logic [W-1:0] period = 16'd100;
  logic [1:0]   cnt_mode = 2'b01;
  logic [1:0]   ld_sel = 2'b00;
  logic         cap_mode = 1'b0;
  logic [W-1:0] latch_q;
  logic         match;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmp_latch_loader #(.W(W)) u_cmp_latch_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cnt(cnt),
    .period(period), .cnt_mode(cnt_mode), .ld_sel(ld_sel), .cap_mode(cap_mode),
    .latch_q(latch_q), .match(match)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, settle away from the edge
  task automatic step(input logic we, input logic [W-1:0] d, input logic [W-1:0] c);
    @(negedge clk);
    wr_en = we; wr_data = d; cnt = c;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 latch at reset", latch_q, 16'h0000);
    @(negedge clk); cnt = 16'd0; #1;
    check("R1 match at zero", {15'd0, match}, 16'd1);
    @(negedge clk); rst_n = 1'b1; cnt = 16'd5;
    ld_sel = 2'b01;
    step(1'b0, '0, 16'd0);
    check("R1 staging cleared", latch_q, 16'h0000);
  endtask

  task automatic t_immediate();
    ld_sel = 2'b00;
    step(1'b1, 16'h1234, 16'd7);
    check("R2 immediate load", latch_q, 16'h1234);
    step(1'b1, 16'hBEEF, 16'd0);
    check("R2 immediate load at zero", latch_q, 16'hBEEF);
    step(1'b1, 16'h1234, 16'd9);
  endtask

  task automatic t_zero();
    ld_sel = 2'b01;
    step(1'b1, 16'h0055, 16'd7);
    check("R7 pending held", latch_q, 16'h1234);
    step(1'b1, 16'h0066, 16'd8);
    check("R7 overwrite held", latch_q, 16'h1234);
    step(1'b0, '0, 16'd0);
    check("R3 R7 zero load latest", latch_q, 16'h0066);
  endtask

  task automatic t_ends_updn();
    ld_sel = 2'b10; cnt_mode = 2'b11;
    step(1'b1, 16'h0011, 16'd50);
    check("R4 no load mid", latch_q, 16'h0066);
    step(1'b0, '0, 16'd100);
    check("R4 load at period", latch_q, 16'h0011);
    step(1'b1, 16'h0022, 16'd60);
    check("R4 no load mid 2", latch_q, 16'h0011);
    step(1'b0, '0, 16'd0);
    check("R4 load at zero", latch_q, 16'h0022);
  endtask

  task automatic t_ends_other();
    ld_sel = 2'b10;
    cnt_mode = 2'b01;
    step(1'b1, 16'h0033, 16'd100);
    check("R5 up: period ignored", latch_q, 16'h0022);
    cnt_mode = 2'b10;
    step(1'b0, '0, 16'd100);
    check("R5 continuous: period ignored", latch_q, 16'h0022);
    step(1'b0, '0, 16'd0);
    check("R5 load at zero", latch_q, 16'h0033);
  endtask

  task automatic t_self();
    ld_sel = 2'b11;
    step(1'b1, 16'h0044, 16'd0);
    check("R6 zero ignored", latch_q, 16'h0033);
    @(negedge clk); cnt = 16'h0033; #1;
    check("R9 match before load", {15'd0, match}, 16'd1);
    @(posedge clk); #1;
    check("R6 self load", latch_q, 16'h0044);
    check("R9 match after load", {15'd0, match}, 16'd0);
  endtask

  task automatic t_same_cycle();
    ld_sel = 2'b01;
    step(1'b1, 16'h0077, 16'd3);
    step(1'b1, 16'h0088, 16'd0);
    check("R10 old value transferred", latch_q, 16'h0077);
    step(1'b0, '0, 16'd0);
    check("R10 new value next event", latch_q, 16'h0088);
  endtask

  task automatic t_capture();
    cap_mode = 1'b1;
    ld_sel = 2'b00;
    step(1'b1, 16'h0099, 16'd4);
    check("R8 write ignored", latch_q, 16'h0088);
    ld_sel = 2'b01;
    step(1'b0, '0, 16'd0);
    check("R8 zero ignored", latch_q, 16'h0088);
    cap_mode = 1'b0;
    step(1'b0, '0, 16'd0);
    check("R8 staging still written", latch_q, 16'h0099);
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_immediate();
    t_zero();
    t_ends_updn();
    t_ends_other();
    t_self();
    t_same_cycle();
    t_capture();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule